// File: doc/BRIEF.md
# Nibble-Permuting Read Data Scrambler

This block sits on the read path of a protected port and scrambles each 16-bit raw word before the host sees it. The caller gives per-port controls alongside the word: four 2-bit nibble selectors, a 2-bit rotate amount for the lowest output nibble, and enables for an XOR stage and a NAND stage. The output is the raw word's nibbles reordered. The lowest nibble is also rotated. After that, the optional XOR stage applies, followed by the optional NAND stage.

The XOR and NAND stages use two key registers. The host loads these keys by writing to fixed local addresses, and the byte enables choose which halves of a key change. The transform itself is combinational. Only the keys hold state.

Top module: `nib_scrambler`

## Requirements
- R1: Output bits [15:12], [11:8] and [7:4] take the raw nibble chosen by sel3_i, sel2_i and sel1_i respectively. Selector value n chooses raw bits [4n+3:4n].
- R2: Output bits [3:0] take the raw nibble chosen by sel0_i, rotated left by rot_i places. For example, rot_i=1 maps nibble n to {n[2:0],n[3]}.
- R3: When xor_en_i is high, the permuted word is XORed with the XOR key.
- R4: When nand_en_i is high, the word is replaced by ~(word & nand key). This stage is applied after the XOR stage.
- R5: A write strobe whose waddr_i[7:0] equals 0x2C loads the XOR key on the next clock edge. A write strobe whose waddr_i[7:0] equals 0x36 loads the NAND key.
- R6: wbe_i[1] gates key bits [15:8] and wbe_i[0] gates key bits [7:0]. Bytes that are not enabled keep their value.
- R7: Both keys are 0x0000 after reset. Writes to any other low address byte leave both keys unchanged.
- R8: The output follows the raw word and the controls with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_i | input | 16 | Raw word before scrambling |
| sel3_i | input | 2 | Source nibble for output [15:12] |
| sel2_i | input | 2 | Source nibble for output [11:8] |
| sel1_i | input | 2 | Source nibble for output [7:4] |
| sel0_i | input | 2 | Source nibble for output [3:0] |
| rot_i | input | 2 | Left rotate amount for the low nibble |
| xor_en_i | input | 1 | Enable the XOR key stage |
| nand_en_i | input | 1 | Enable the NAND key stage |
| we_i | input | 1 | Host write strobe |
| waddr_i | input | 16 | Host local write address |
| wdata_i | input | 16 | Host write data |
| wbe_i | input | 2 | Byte enables (bit 1 = high byte) |
| data_o | output | 16 | Scrambled word |

## Verification
The only state is the two keys. A corrupted key is invisible while its stage is disabled. It shows on data_o in the same cycle that the stage is enabled. With raw=0 and an identity mapping, the XOR stage presents the XOR key directly. With raw=0xFFFF, the NAND stage presents the inverted NAND key. Loading a key through a wrong address or byte lane is exposed by the first read after the following clock edge.

// File: rtl/nib_scrambler_pkg.sv
package nib_scrambler_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned NIB_W  = 4;
  localparam int unsigned NUM_NIB = WORD_W / NIB_W;
  localparam int unsigned SEL_W   = $clog2(NUM_NIB);
  localparam int unsigned ROT_W   = $clog2(NIB_W);
  localparam int unsigned BE_W    = WORD_W / 8;
  localparam logic [7:0] XOR_KEY_ADDR  = 8'h2C;
  localparam logic [7:0] NAND_KEY_ADDR = 8'h36;
endpackage

// File: rtl/nib_permute.sv
module nib_permute
  import nib_scrambler_pkg::*;
(
  input  logic [WORD_W-1:0]              raw_i,
  input  logic [NUM_NIB-1:0][SEL_W-1:0]  sel_i,
  input  logic [ROT_W-1:0]               rot_i,
  output logic [WORD_W-1:0]              perm_o
);
  logic [NUM_NIB-1:0][NIB_W-1:0] src;
  assign src = raw_i;

  for (genvar g = 1; g < NUM_NIB; g++) begin : g_nib
    assign perm_o[g*NIB_W +: NIB_W] = src[sel_i[g]];
  end

  // low nibble: rotate left
  logic [NIB_W-1:0]   low;
  logic [2*NIB_W-1:0] dbl;
  assign low = src[sel_i[0]];
  assign dbl = {low, low} << rot_i;
  assign perm_o[NIB_W-1:0] = dbl[2*NIB_W-1:NIB_W];
endmodule

// File: rtl/key_regs.sv
module key_regs
  import nib_scrambler_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [15:0]       waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   wbe_i,
  output logic [WORD_W-1:0] xor_key_o,
  output logic [WORD_W-1:0] nand_key_o
);
  logic hit_xor, hit_nand;
  assign hit_xor  = we_i && (waddr_i[7:0] == XOR_KEY_ADDR);
  assign hit_nand = we_i && (waddr_i[7:0] == NAND_KEY_ADDR);

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        xor_key_o[b*8 +: 8]  <= '0;
        nand_key_o[b*8 +: 8] <= '0;
      end else begin
        if (hit_xor && wbe_i[b])  xor_key_o[b*8 +: 8]  <= wdata_i[b*8 +: 8];
        if (hit_nand && wbe_i[b]) nand_key_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/nib_scrambler.sv
module nib_scrambler
  import nib_scrambler_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] raw_i,
  input  logic [1:0]  sel3_i,
  input  logic [1:0]  sel2_i,
  input  logic [1:0]  sel1_i,
  input  logic [1:0]  sel0_i,
  input  logic [1:0]  rot_i,
  input  logic        xor_en_i,
  input  logic        nand_en_i,
  input  logic        we_i,
  input  logic [15:0] waddr_i,
  input  logic [15:0] wdata_i,
  input  logic [1:0]  wbe_i,
  output logic [15:0] data_o
);
  logic [WORD_W-1:0] perm, xored, xor_key, nand_key;

  nib_permute i_perm (
    .raw_i  (raw_i),
    .sel_i  ({sel3_i, sel2_i, sel1_i, sel0_i}),
    .rot_i  (rot_i),
    .perm_o (perm)
  );

  key_regs i_keys (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .waddr_i    (waddr_i),
    .wdata_i    (wdata_i),
    .wbe_i      (wbe_i),
    .xor_key_o  (xor_key),
    .nand_key_o (nand_key)
  );

  assign xored  = xor_en_i ? (perm ^ xor_key) : perm;
  assign data_o = nand_en_i ? ~(xored & nand_key) : xored;
endmodule

// File: rtl/nib_scrambler_chk.sv
module nib_scrambler_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] raw_i,
  input logic [1:0]  sel3_i,
  input logic [1:0]  sel2_i,
  input logic [1:0]  sel1_i,
  input logic [1:0]  sel0_i,
  input logic [1:0]  rot_i,
  input logic        xor_en_i,
  input logic        nand_en_i,
  input logic        we_i,
  input logic [15:0] waddr_i,
  input logic [15:0] wbe_i_ext,
  input logic [15:0] data_o
);
  // R1
  identity_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel3_i == 2'd3 && sel2_i == 2'd2 && sel1_i == 2'd1 && !xor_en_i && !nand_en_i)
      |-> data_o[15:4] == raw_i[15:4]);
  // R2
  low_rot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_i == 2'd0 && rot_i == 2'd0 && !xor_en_i && !nand_en_i)
      |-> data_o[3:0] == raw_i[3:0]);
  // R4
  nand_zero_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == 16'h0 && !xor_en_i && nand_en_i) |-> data_o == 16'hFFFF);
  // R7
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && $stable(raw_i) && $stable({sel3_i,sel2_i,sel1_i,sel0_i,rot_i,xor_en_i,nand_en_i}))
      |=> $stable(data_o));
  // R6
  no_be_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wbe_i_ext[1:0] == 2'b00 && $stable(raw_i) && $stable({sel3_i,sel2_i,sel1_i,sel0_i,rot_i,xor_en_i,nand_en_i}))
      |=> $stable(data_o));
endmodule

bind nib_scrambler nib_scrambler_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_i),
  .sel3_i(sel3_i), .sel2_i(sel2_i), .sel1_i(sel1_i), .sel0_i(sel0_i),
  .rot_i(rot_i), .xor_en_i(xor_en_i), .nand_en_i(nand_en_i),
  .we_i(we_i), .waddr_i(waddr_i), .wbe_i_ext({14'd0, wbe_i}), .data_o(data_o)
);

// File: tb/test_nib_scrambler.sv
`timescale 1ns/1ps
module test_nib_scrambler;
  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] raw_i = 0, waddr_i = 0, wdata_i = 0;
  logic [1:0]  sel3_i = 3, sel2_i = 2, sel1_i = 1, sel0_i = 0, rot_i = 0, wbe_i = 0;
  logic        xor_en_i = 0, nand_en_i = 0, we_i = 0;
  logic [15:0] data_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  nib_scrambler i_nib_scrambler (.*);

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (data_o !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, data_o, exp);
    end
  endtask

  task automatic set_ctl(input logic [1:0] s3, s2, s1, s0, r, input logic xe, ne);
    sel3_i = s3; sel2_i = s2; sel1_i = s1; sel0_i = s0; rot_i = r;
    xor_en_i = xe; nand_en_i = ne;
  endtask

  task automatic wr(input logic [15:0] a, d, input logic [1:0] be);
    @(negedge clk_i);
    we_i = 1; waddr_i = a; wdata_i = d; wbe_i = be;
    @(negedge clk_i);
    we_i = 0; wbe_i = 0;
  endtask

  function automatic logic [3:0] nib(input logic [15:0] w, input logic [1:0] s);
    return w[s*4 +: 4];
  endfunction

  function automatic logic [3:0] rotl(input logic [3:0] n, input logic [1:0] r);
    case (r)
      2'd0: return n;
      2'd1: return {n[2:0], n[3]};
      2'd2: return {n[1:0], n[3:2]};
      default: return {n[0], n[3:1]};
    endcase
  endfunction

  task automatic t_reset;
    // R7: keys zero after reset -> xor with raw 0 gives 0, nand with raw FFFF gives FFFF
    set_ctl(3,2,1,0,0,1,0); raw_i = 16'h0000; #1; check("R7 reset xor key", 16'h0000);
    set_ctl(3,2,1,0,0,0,1); raw_i = 16'hFFFF; #1; check("R7 reset nand key", 16'hFFFF);
  endtask

  task automatic t_perm;
    logic [15:0] exp;
    raw_i = 16'hA5C3;
    for (int i = 0; i < 6; i++) begin
      logic [1:0] s3 = 2'(i), s2 = 2'(i+1), s1 = 2'(3-i), s0 = 2'(i*3), r = 2'(i);
      set_ctl(s3,s2,s1,s0,r,0,0); #1;
      exp = {nib(raw_i,s3), nib(raw_i,s2), nib(raw_i,s1), rotl(nib(raw_i,s0), r)};
      check("R1 R2 permute", exp);
    end
    set_ctl(0,0,0,3,1,0,0); raw_i = 16'h8001; #1;
    check("R2 rotate 1", {4'h1,4'h1,4'h1,4'h1});
    raw_i = 16'h1234; #1; // R8 no latency
    check("R8 comb", {4'h4,4'h4,4'h4,rotl(4'h1,1)});
  endtask

  task automatic t_keys;
    wr(16'h3F2C, 16'hBEEF, 2'b11);
    set_ctl(3,2,1,0,0,1,0); raw_i = 16'h0000; #1; check("R5 xor key load", 16'hBEEF);
    raw_i = 16'h1234; #1; check("R3 xor stage", 16'h1234 ^ 16'hBEEF);
    wr(16'h0036, 16'h0FF0, 2'b11);
    set_ctl(3,2,1,0,0,0,1); raw_i = 16'hFFFF; #1; check("R5 nand key load", 16'hF00F);
    set_ctl(3,2,1,0,0,1,1); raw_i = 16'h1234; #1;
    check("R4 xor then nand", ~((16'h1234 ^ 16'hBEEF) & 16'h0FF0));
    wr(16'h002C, 16'h1100, 2'b10);
    set_ctl(3,2,1,0,0,1,0); raw_i = 0; #1; check("R6 high byte only", 16'h11EF);
    wr(16'h002C, 16'h2233, 2'b01);
    #1; check("R6 low byte only", 16'h1133);
    wr(16'h002C, 16'hFFFF, 2'b00);
    #1; check("R6 no enables", 16'h1133);
    wr(16'h002D, 16'h5555, 2'b11);
    wr(16'h0136, 16'h5555, 2'b00);
    #1; check("R7 other address xor", 16'h1133);
    set_ctl(3,2,1,0,0,0,1); raw_i = 16'hFFFF; #1; check("R7 other address nand", 16'hF00F);
  endtask

  initial begin
    fork
      begin
        #20 rst_ni = 1;
        @(negedge clk_i);
        t_reset();
        t_perm();
        t_keys();
      end
      begin
        repeat (100000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule